// File: doc/BRIEF.md
# Multi-Format Synchronous Serial Port

This block is a synchronous serial port that works either as the bus master or as a slave. As master it generates the bit clock and the select/frame-sync line. It shifts words out on master-out and captures master-in. As slave it follows an external clock and select, captures master-out and drives master-in. A single shifter serves three frame formats:

- SPI-style, with an active-low select and a programmable clock polarity.
- SSI-style, with a one-slot high frame-sync pulse ahead of the data.
- Microwire-style, with an active-high chip select.

Software reaches the block through five word registers, addressed by a 3-bit index:

| Index | Register | Fields |
|-------|----------|--------|
| 0 | control 0 | [3:0] size, [5:4] format (0 SPI, 1 SSI, 2 Microwire, 3 as SPI), [6] clock polarity, [15:8] rate |
| 1 | control 1 | [0] enable, [1] slave |
| 2 | data | write fills the transmit FIFO, read drains the receive FIFO |
| 3 | status | read-only |
| 4 | prescale | [7:1] prescale |

Every pin has its own output enable, so the pad can be released to high impedance. The bit clock toggles only inside a frame. A deselected slave leaves master-in undriven.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, indices 0, 1, 2 and 4 read 0, status (index 3) reads 0x0003, and every output enable is low.
- R2: Control 0 reads back all 16 written bits. Control 1 reads back only bits [1:0]. Prescale reads back bits [7:1] with bit 0 always 0.
- R3: Writes to index 2 push into an 8-entry transmit FIFO. A write while it is full is dropped. Status bit 0 means the transmit FIFO is empty and bit 1 means it is not full.
- R4: In master mode, each half bit period lasts max(1, prescale/2) × (rate + 1) system clocks, where prescale/2 is bits [7:1].
- R5: A master frame carries N = size + 1 bits (size below 3 acts as 3). Bits go out MSB first on master-out, are captured from master-in on each leading clock edge, and the word lands right-justified in the receive FIFO (status bit 2 = not empty, bit 3 = full).
- R6: In SPI format the clock idles at the polarity bit. Select is low from at least half a bit before the first clock edge through every leading edge, and idles high.
- R7: In SSI format the clock idles low whatever the polarity bit says. Frame-sync is high for one clock slot just before the MSB slot and low at every data leading edge, so a frame has 2(N+1) clock edges.
- R8: In Microwire format the clock idles low whatever the polarity bit says. Select is high through every leading edge of the frame and idles low.
- R9: A master frame has exactly 2N clock edges (SPI, Microwire) and the clock holds its idle level between frames. With enable low, or in slave mode, the clock, select and master-out enables are low.
- R10: In slave SPI mode, master-out is sampled on each leading edge of the external clock while select is low. After N bits the right-justified word is pushed into the receive FIFO.
- R11: A slave drives master-in only while selected, and sends its transmit FIFO head MSB first, changing on trailing edges.
- R12: A received word that finds the receive FIFO full is dropped and sets status bit 5. Any write to control 1 clears that bit.
- R13: Status bit 4 (busy) is high while a frame is pending or in progress and low once the port is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | 3 | Register word index |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops receive FIFO at index 2) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational on reg_idx |
| sck_o | output | 1 | Bit clock out (master) |
| sck_oe | output | 1 | Bit clock output enable |
| sck_i | input | 1 | Bit clock in (slave) |
| sel_o | output | 1 | Select / frame-sync out |
| sel_oe | output | 1 | Select output enable |
| sel_i | input | 1 | Select / frame-sync in |
| mosi_o | output | 1 | Master-out data |
| mosi_oe | output | 1 | Master-out enable |
| mosi_i | input | 1 | Master-out data seen by a slave |
| miso_o | output | 1 | Master-in data driven as slave |
| miso_oe | output | 1 | Master-in enable |
| miso_i | input | 1 | Master-in data sampled as master |

## Verification
A corrupted divider or slot counter shows up within one frame, as a wrong gap between the first two clock edges or a wrong total edge count. A shifter that slips a position returns a received word that differs from the looped-back one as soon as that frame completes. A FIFO pointer or count error appears in the status bits, or in the order of words read back, no later than the ninth word. A broken select or tri-state rule is visible at the pins on the first edge of the affected frame.

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_idx,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        sck_o,
  output logic        sck_oe,
  input  logic        sck_i,
  output logic        sel_o,
  output logic        sel_oe,
  input  logic        sel_i,
  output logic        mosi_o,
  output logic        mosi_oe,
  input  logic        mosi_i,
  output logic        miso_o,
  output logic        miso_oe,
  input  logic        miso_i
);
  localparam int AW = $clog2(DEPTH);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_GAP} st_t;

  logic [15:0] ctl0;
  logic [1:0]  ctl1;
  logic [7:1]  psc;
  logic        ovr;

  wire [3:0]  dss    = (ctl0[3:0] < 4'd3) ? 4'd3 : ctl0[3:0];
  wire        is_ssi = ctl0[5:4] == 2'd1;
  wire        is_mw  = ctl0[5:4] == 2'd2;
  wire        is_spi = !is_ssi && !is_mw;
  wire        pol    = is_spi & ctl0[6];
  wire        m_on   = ctl1[0] & !ctl1[1];
  wire        s_on   = ctl1[0] & ctl1[1];
  wire [15:0] mask   = 16'hFFFF >> (4'd15 - dss);

  // FIFOs
  logic [15:0]   txm [DEPTH];
  logic [15:0]   rxm [DEPTH];
  logic [AW-1:0] twp, trp, rwp, rrp;
  logic [AW:0]   tcnt, rcnt;
  wire tx_empty = tcnt == 0;
  wire tx_full  = tcnt == DEPTH[AW:0];
  wire rx_empty = rcnt == 0;
  wire rx_full  = rcnt == DEPTH[AW:0];

  // shifter state
  st_t         st;
  logic [15:0] div, sh, rsh;
  logic [5:0]  ph;
  logic        sck_act, fs;
  logic [2:0]  sck_q;
  logic [1:0]  sel_q, mosi_q;
  logic [3:0]  s_cnt;
  logic        s_frm, s_got, s_ld;

  wire [15:0] hp       = {9'd0, (psc == 7'd0) ? 7'd1 : psc} * ({8'd0, ctl0[15:8]} + 16'd1);
  wire        tick     = div == hp - 16'd1;
  wire [4:0]  nsl      = {1'b0, dss} + 5'd1 + {4'd0, is_ssi};
  wire [5:0]  lastph   = {nsl - 5'd1, 1'b1};
  wire        sync_slt = is_ssi && ph[5:1] == 5'd0;

  wire sck_c   = sck_q[1] ^ pol;
  wire sck_p   = sck_q[2] ^ pol;
  wire s_lead  = sck_c & !sck_p;
  wire s_trail = !sck_c & sck_p;
  wire s_sel   = is_spi ? !sel_q[1] : is_mw ? sel_q[1] : (sel_q[1] | s_frm);
  wire [15:0] nrx = {rsh[14:0], mosi_q[1]};

  wire m_start = m_on && st == S_IDLE && !tx_empty;
  wire s_load  = s_on && !s_ld && !tx_empty && s_cnt == 4'd0 && !s_got;
  wire push_m  = m_on && st == S_RUN && tick && ph == lastph;
  wire push_s  = s_on && s_sel && s_lead && (!is_ssi || s_frm) && s_cnt == dss;
  wire push    = push_m | push_s;
  wire [15:0] push_val = (push_m ? rsh : nrx) & mask;

  wire tx_push = wr_en && reg_idx == 3'd2 && !tx_full;
  wire tx_pop  = m_start | s_load;
  wire rx_push = push && !rx_full;
  wire rx_pop  = rd_en && reg_idx == 3'd2 && !rx_empty;
  wire busy    = st != S_IDLE || (m_on && !tx_empty) || (s_on && (s_frm || s_cnt != 4'd0));

  assign sck_o   = sck_act ^ pol;
  assign sel_o   = is_ssi ? fs : is_mw ? (st == S_RUN) : (st != S_RUN);
  assign mosi_o  = sh[dss];
  assign miso_o  = sh[dss];
  assign sck_oe  = m_on;
  assign sel_oe  = m_on;
  assign mosi_oe = m_on;
  assign miso_oe = s_on & s_sel;

  always_comb begin
    case (reg_idx)
      3'd0:    rdata = ctl0;
      3'd1:    rdata = {14'd0, ctl1};
      3'd2:    rdata = rx_empty ? 16'd0 : rxm[rrp];
      3'd3:    rdata = {10'd0, ovr, busy, rx_full, !rx_empty, !tx_full, tx_empty};
      3'd4:    rdata = {8'd0, psc, 1'b0};
      default: rdata = 16'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl0 <= '0; ctl1 <= '0; psc <= '0; ovr <= 1'b0;
    end else begin
      if (wr_en && reg_idx == 3'd0) ctl0 <= wdata;
      if (wr_en && reg_idx == 3'd1) ctl1 <= wdata[1:0];
      if (wr_en && reg_idx == 3'd4) psc  <= wdata[7:1];
      if (push && rx_full) ovr <= 1'b1;
      else if (wr_en && reg_idx == 3'd1) ovr <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) txm[twp] <= wdata;
    if (rx_push) rxm[rwp] <= push_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      twp <= '0; trp <= '0; rwp <= '0; rrp <= '0; tcnt <= '0; rcnt <= '0;
    end else begin
      if (tx_push) twp <= twp + 1'b1;
      if (tx_pop)  trp <= trp + 1'b1;
      if (rx_push) rwp <= rwp + 1'b1;
      if (rx_pop)  rrp <= rrp + 1'b1;
      if (tx_push && !tx_pop) tcnt <= tcnt + 1'b1;
      else if (!tx_push && tx_pop) tcnt <= tcnt - 1'b1;
      if (rx_push && !rx_pop) rcnt <= rcnt + 1'b1;
      else if (!rx_push && rx_pop) rcnt <= rcnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; div <= '0; ph <= '0; sck_act <= 1'b0; fs <= 1'b0;
      sh <= '0; rsh <= '0; sck_q <= '0; sel_q <= '1; mosi_q <= '0;
      s_cnt <= '0; s_frm <= 1'b0; s_got <= 1'b0; s_ld <= 1'b0;
    end else begin
      sck_q  <= {sck_q[1:0], sck_i};
      sel_q  <= {sel_q[0], sel_i};
      mosi_q <= {mosi_q[0], mosi_i};
      if (!m_on) begin
        st <= S_IDLE; sck_act <= 1'b0; fs <= 1'b0; div <= '0;
      end else begin
        case (st)
          S_IDLE: if (!tx_empty) begin
            st <= S_RUN; sh <= txm[trp]; rsh <= '0; div <= '0; ph <= '0;
            sck_act <= 1'b0; fs <= is_ssi;
          end
          S_RUN: begin
            div <= tick ? '0 : div + 16'd1;
            if (tick) begin
              ph <= ph + 6'd1;
              sck_act <= !ph[0];
              if (!ph[0] && !sync_slt) rsh <= {rsh[14:0], miso_i};
              if (ph[0]) begin
                fs <= 1'b0;
                if (!sync_slt) sh <= sh << 1;
                if (ph == lastph) st <= S_GAP;
              end
            end
          end
          default: begin
            div <= tick ? '0 : div + 16'd1;
            if (tick) st <= S_IDLE;
          end
        endcase
      end
      if (s_on) begin
        if (s_load) begin sh <= txm[trp]; s_ld <= 1'b1; end
        if (!s_sel) begin
          s_cnt <= '0; s_got <= 1'b0;
        end else if (s_lead) begin
          if (is_ssi && !s_frm) begin
            s_frm <= 1'b1; s_cnt <= '0;
          end else begin
            rsh <= nrx; s_got <= 1'b1;
            if (s_cnt == dss) begin
              s_cnt <= '0; s_frm <= 1'b0; s_ld <= 1'b0; sh <= '0;
            end else s_cnt <= s_cnt + 4'd1;
          end
        end else if (s_trail && s_got) begin
          sh <= sh << 1; s_got <= 1'b0;
        end
      end else begin
        s_cnt <= '0; s_frm <= 1'b0; s_got <= 1'b0; s_ld <= 1'b0;
      end
    end
  end

  assert_fifo_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt <= DEPTH[AW:0] && rcnt <= DEPTH[AW:0]);
  assert_full_write_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && wr_en && reg_idx == 3'd2) |=> tcnt <= $past(tcnt));
  assert_idle_clock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_RUN) |-> sck_o == pol);
  assert_spi_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_on && is_spi && $stable(ctl0) && $stable(ctl1) && sck_o != $past(sck_o)) |-> !$past(sel_o));
  assert_rx_full_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !(rd_en && reg_idx == 3'd2)) |=> rcnt == DEPTH[AW:0]);
endmodule

// File: tb/sync_serial_port_bench.sv
module sync_serial_port_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_idx = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic sck_o, sck_oe, sel_o, sel_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic sck_i = 1'b0, sel_i = 1'b1, mosi_i = 1'b0;
  wire  miso_i = mosi_o;
  int nvec = 0, nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sync_serial_port u_sync_serial_port (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i),
    .sel_o(sel_o), .sel_oe(sel_oe), .sel_i(sel_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .mosi_i(mosi_i), .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i));

  // {size[38:35], fmt[34:33], cpol[32], rate[31:24], prescale[23:16], word[15:0]}
  localparam logic [38:0] VEC [6] = '{
    {4'd7,  2'd0, 1'b0, 8'd0, 8'd2, 16'h00A5},
    {4'd15, 2'd0, 1'b1, 8'd1, 8'd4, 16'hBEEF},
    {4'd11, 2'd1, 1'b1, 8'd0, 8'd6, 16'hF5A3},
    {4'd3,  2'd2, 1'b1, 8'd2, 8'd2, 16'hFFF9},
    {4'd4,  2'd0, 1'b0, 8'd0, 8'd0, 16'h0015},
    {4'd3,  2'd1, 1'b0, 8'd0, 8'd3, 16'h000A}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [15:0] d);
    @(negedge clk); reg_idx = idx; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [15:0] d);
    @(negedge clk); reg_idx = idx; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk); reg_idx = 3'd3;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!rdata[4]) break;
    end
  endtask

  task automatic run_vec(input logic [38:0] v);
    logic [3:0] sz = v[38:35];
    logic [1:0] fm = v[34:33];
    int n = int'(sz) + 1;
    int half = ((v[23:17] == 0) ? 1 : int'(v[23:17])) * (int'(v[31:24]) + 1);
    int exp_edges = 2 * (n + ((fm == 2'd1) ? 1 : 0));
    logic idle_sck = (fm == 2'd0) ? v[32] : 1'b0;
    logic idle_sel = (fm == 2'd0);
    int edges = 0, t1 = 0, t2 = 0, selbad = 0, cyc = 0;
    bit seen_busy = 0;
    logic psck, psel;
    logic [15:0] r;
    wr(3'd1, 16'h0000);
    wr(3'd0, {v[31:24], 1'b0, v[32], fm, sz});
    wr(3'd4, {8'd0, v[23:16]});
    wr(3'd1, 16'h0001);
    check("R9 clock idle level", sck_o, idle_sck);
    check("R6/R7/R8 select idle level", sel_o, idle_sel);
    wr(3'd2, v[15:0]);
    reg_idx = 3'd3; psck = sck_o; psel = sel_o;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); cyc++;
      if (rdata[4]) seen_busy = 1;
      if (sck_o != psck) begin
        edges++;
        if (edges == 1) t1 = cyc;
        if (edges == 2) t2 = cyc;
        if (edges % 2 == 1) begin
          if (fm == 2'd0 && psel !== 1'b0) selbad++;
          if (fm == 2'd2 && psel !== 1'b1) selbad++;
          if (fm == 2'd1 && psel !== (edges == 1)) selbad++;
        end
      end
      psck = sck_o; psel = sel_o;
      if (seen_busy && !rdata[4]) break;
    end
    check("R13 busy seen during frame", 32'(seen_busy), 1);
    check("R9 clock edge count", edges, exp_edges);
    check("R4 half bit period", t2 - t1, half);
    check("R6/R7/R8 select at leading edges", selbad, 0);
    check("R9 clock idle after frame", sck_o, idle_sck);
    check("R6/R7/R8 select idle after frame", sel_o, idle_sel);
    rd(3'd2, r);
    check("R5 received word", r, v[15:0] & (16'hFFFF >> (15 - int'(sz))));
  endtask

  initial begin
    logic [15:0] r;
    logic [7:0] got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); reg_idx = 3'(k); #1;
      check("R1 reset register value", rdata, (k == 3) ? 16'h0003 : 16'h0000);
    end
    check("R1 output enables low", {sck_oe, sel_oe, mosi_oe, miso_oe}, 0);
    // R2 readback
    wr(3'd0, 16'hAB7C); rd(3'd0, r); check("R2 control 0 readback", r, 16'hAB7C);
    wr(3'd4, 16'h00FF); rd(3'd4, r); check("R2 prescale bit0 reads 0", r, 16'h00FE);
    wr(3'd1, 16'hFFFC); rd(3'd1, r); check("R2 control 1 width", r, 16'h0000);

    foreach (VEC[i]) run_vec(VEC[i]);

    // R3 / R12: transmit full, receive full, overrun
    wr(3'd1, 16'h0000); wr(3'd0, 16'h0007); wr(3'd4, 16'h0002);
    for (int i = 0; i < 8; i++) wr(3'd2, 16'h0010 + 16'(i));
    rd(3'd3, r); check("R3 transmit full flags", r[1:0], 2'b00);
    wr(3'd2, 16'h00EE);
    wr(3'd1, 16'h0001);
    wait_idle();
    rd(3'd3, r);
    check("R5 receive full and not empty", r[3:2], 2'b11);
    check("R12 no overrun at exactly eight", r[5], 0);
    check("R3 transmit empty after dropped write", r[1:0], 2'b11);
    wr(3'd2, 16'h0077);
    wait_idle();
    rd(3'd3, r); check("R12 overrun flag set", r[5], 1);
    for (int i = 0; i < 8; i++) begin
      rd(3'd2, r); check("R3 R12 FIFO order", r, 16'h0010 + 16'(i));
    end
    rd(3'd3, r); check("R12 dropped word absent", r[2], 0);
    wr(3'd1, 16'h0001); rd(3'd3, r); check("R12 overrun cleared", r[5], 0);
    wr(3'd1, 16'h0000);
    check("R9 disabled enables low", {sck_oe, sel_oe, mosi_oe}, 0);

    // R10 / R11 slave SPI
    wr(3'd0, 16'h0007); wr(3'd2, 16'h00A5); wr(3'd1, 16'h0003);
    repeat (4) @(negedge clk);
    check("R11 master-in released when deselected", miso_oe, 0);
    check("R9 slave mode master pins released", {sck_oe, sel_oe, mosi_oe}, 0);
    sel_i = 1'b0;
    repeat (4) @(negedge clk);
    check("R11 master-in driven when selected", miso_oe, 1);
    for (int b = 7; b >= 0; b--) begin
      mosi_i = 8'h3C >> b;
      repeat (4) @(negedge clk);
      got[b] = miso_o;
      sck_i = 1'b1; repeat (4) @(negedge clk);
      sck_i = 1'b0; repeat (4) @(negedge clk);
    end
    check("R11 slave sends MSB first", got, 8'hA5);
    rd(3'd2, r); check("R10 slave received word", r, 16'h003C);
    sel_i = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 master-in released after frame", miso_oe, 0);
    rd(3'd3, r); check("R13 idle after slave frame", r[4], 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nvec++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule